// File: doc/BRIEF.md
# Error-Weighted Link Quality Monitor

This block judges the health of a framed serial link. It watches a one-cycle end-of-scan strobe and the index of the current word inside the minor frame. Strobes that fall in the data words (words 1 to 23) drive a chain of three divide-by-ten stages. A two-bit rate select picks one tap of that chain, and the tap feeds a modulo-16 threshold counter. When the threshold counter sits at 15, the link may earn credit.

In the overhead word (word 28) an overhead counter is preset to fifteen minus an error count of 0 to 7. The error count is one of three inputs, picked by two enables. The overhead counter then steps up on every later strobe and stops at 15. A frame that reported errors therefore holds off credit for that many strobes.

A saturating 4-bit quality counter acts on every strobe. It rises when both the threshold counter and the overhead counter are at 15, and falls otherwise. The error flag is raised while the quality count is at or below the low mark of 3. The flag has no memory: it drops again as soon as the count recovers.

Top module: `link_quality_monitor`

## Requirements
- R1: A strobe advances the decade prescaler only when word_idx is between 1 and 23 inclusive. Strobes in any other word leave the prescaler unchanged.
- R2: rate_sel chooses how many qualifying strobes it takes to step the threshold counter once: 0 means every strobe, 1 means 1 in 10, 2 means 1 in 100 and 3 means 1 in 1000. Counting starts from reset.
- R3: The threshold counter counts modulo 16. It grants credit only while its value is 15.
- R4: A strobe with word_idx equal to 28 loads the overhead counter with {1, ~err}, which equals 15 minus err. err is err_a when sel_a is 1, otherwise err_b when sel_b is 1, otherwise err_c.
- R5: Every other strobe increments the overhead counter while it is below 15. Once it reaches 15 it holds there until the next word-28 load. It grants credit only while its value is 15.
- R6: On a strobe with both credits granted, the quality count increments if it is below 15. At 15 it holds.
- R7: On a strobe with either credit missing, the quality count decrements if it is above 0. At 0 it holds.
- R8: The quality count changes only on cycles with scan_stb high.
- R9: link_err is 1 exactly when the quality count is 3 or less.
- R10: After reset the prescaler and the threshold counter are 0, and the overhead and quality counters are 15. The quality output therefore reads 15 and link_err reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_stb | input | 1 | One-cycle end-of-scan strobe per word |
| word_idx | input | 5 | Index of the current word in the minor frame |
| rate_sel | input | 2 | Credit rate select (decade tap) |
| err_a | input | 3 | Error count, first source |
| err_b | input | 3 | Error count, second source |
| err_c | input | 3 | Error count, fallback source |
| sel_a | input | 1 | Use err_a at the overhead load |
| sel_b | input | 1 | Use err_b when sel_a is low |
| quality | output | 4 | Quality count |
| link_err | output | 1 | Link poor: quality at or below 3 |

## Verification
Each counter is a single register stage. The effect of a strobe on quality is visible one clock after that strobe, and link_err is combinational on quality, so it changes in that same cycle. The credit that decides a strobe's direction comes from the threshold and overhead counts held before that strobe. A word-28 load therefore first affects the strobe that follows it. The bench drives inputs on the falling edge, steps a behavioural model once for each rising edge, and compares quality and link_err on the next falling edge, exactly one clock after the drive.

// File: rtl/lqm_pkg.sv
package lqm_pkg;
    typedef enum logic [1:0] {
        SRC_FIRST    = 2'd0,
        SRC_SECOND   = 2'd1,
        SRC_FALLBACK = 2'd2
    } err_src_e;
endpackage

// File: rtl/lqm_prescaler.sv
module lqm_prescaler #(
    parameter int DIV        = 10,
    parameter int STAGES     = 3,
    parameter int WORD_W     = 5,
    parameter int FIRST_WORD = 1,
    parameter int LAST_WORD  = 23,
    parameter int SEL_W      = $clog2(STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_stb,
    input  logic [WORD_W-1:0] word_idx,
    input  logic [SEL_W-1:0]  rate_sel,
    output logic              tick
);
    localparam int DW = $clog2(DIV);
    localparam logic [DW-1:0] LAST_DIGIT = DW'(DIV - 1);

    typedef struct packed {
        logic [STAGES-1:0][DW-1:0] dig;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [STAGES:0] tap;

    assign tap[0] = scan_stb
                  && (word_idx >= WORD_W'(FIRST_WORD))
                  && (word_idx <= WORD_W'(LAST_WORD));

    for (genvar k = 0; k < STAGES; k++) begin : g_carry
        assign tap[k+1] = tap[k] && (st_q.dig[k] == LAST_DIGIT);
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < STAGES; k++) begin
            if (tap[k]) begin
                st_d.dig[k] = (st_q.dig[k] == LAST_DIGIT) ? '0 : st_q.dig[k] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (int'(rate_sel) <= STAGES) ? tap[rate_sel] : 1'b0;
endmodule

// File: rtl/lqm_threshold.sv
module lqm_threshold #(
    parameter int THR_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic thr_tc
);
    typedef struct packed {
        logic [THR_W-1:0] cnt;
    } thr_st_t;

    thr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign thr_tc = &st_q.cnt;
endmodule

// File: rtl/lqm_overhead.sv
module lqm_overhead
    import lqm_pkg::*;
#(
    parameter int ERR_W    = 3,
    parameter int WORD_W   = 5,
    parameter int OVH_WORD = 28,
    parameter int OVH_W    = ERR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_stb,
    input  logic [WORD_W-1:0] word_idx,
    input  logic [ERR_W-1:0]  err_a,
    input  logic [ERR_W-1:0]  err_b,
    input  logic [ERR_W-1:0]  err_c,
    input  logic              sel_a,
    input  logic              sel_b,
    output logic [OVH_W-1:0]  ovh_cnt,
    output logic              ovh_tc
);
    typedef struct packed {
        logic [OVH_W-1:0] cnt;
    } ovh_st_t;

    ovh_st_t          st_d, st_q;
    err_src_e         src;
    logic [ERR_W-1:0] err_pick;
    logic             load;

    always_comb begin
        if (sel_a)      src = SRC_FIRST;
        else if (sel_b) src = SRC_SECOND;
        else            src = SRC_FALLBACK;
        case (src)
            SRC_FIRST:  err_pick = err_a;
            SRC_SECOND: err_pick = err_b;
            default:    err_pick = err_c;
        endcase
    end

    assign load = scan_stb && (word_idx == WORD_W'(OVH_WORD));

    always_comb begin
        st_d = st_q;
        if (load)                     st_d.cnt = {1'b1, ~err_pick};
        else if (scan_stb && !ovh_tc) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign ovh_cnt = st_q.cnt;
    assign ovh_tc  = &st_q.cnt;
endmodule

// File: rtl/lqm_quality.sv
module lqm_quality #(
    parameter int Q_W      = 4,
    parameter int LOW_MARK = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scan_stb,
    input  logic           credit,
    output logic [Q_W-1:0] quality,
    output logic           link_err
);
    localparam logic [Q_W-1:0] Q_MAX = '1;

    typedef struct packed {
        logic [Q_W-1:0] q;
    } q_st_t;

    q_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (scan_stb) begin
            if (credit) begin
                if (st_q.q != Q_MAX) st_d.q = st_q.q + 1'b1;
            end else begin
                if (st_q.q != '0)    st_d.q = st_q.q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign quality  = st_q.q;
    assign link_err = (st_q.q <= Q_W'(LOW_MARK));
endmodule

// File: rtl/link_quality_monitor.sv
module link_quality_monitor #(
    parameter int WORD_W     = 5,
    parameter int ERR_W      = 3,
    parameter int Q_W        = 4,
    parameter int THR_W      = 4,
    parameter int DIV        = 10,
    parameter int STAGES     = 3,
    parameter int FIRST_WORD = 1,
    parameter int LAST_WORD  = 23,
    parameter int OVH_WORD   = 28,
    parameter int LOW_MARK   = 3,
    parameter int SEL_W      = $clog2(STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_stb,
    input  logic [WORD_W-1:0] word_idx,
    input  logic [SEL_W-1:0]  rate_sel,
    input  logic [ERR_W-1:0]  err_a,
    input  logic [ERR_W-1:0]  err_b,
    input  logic [ERR_W-1:0]  err_c,
    input  logic              sel_a,
    input  logic              sel_b,
    output logic [Q_W-1:0]    quality,
    output logic              link_err
);
    localparam int OVH_W = ERR_W + 1;

    logic             tick;
    logic             thr_tc;
    logic             ovh_tc;
    logic [OVH_W-1:0] ovh_cnt;
    logic             credit;

    lqm_prescaler #(
        .DIV(DIV), .STAGES(STAGES), .WORD_W(WORD_W),
        .FIRST_WORD(FIRST_WORD), .LAST_WORD(LAST_WORD), .SEL_W(SEL_W)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb),
        .word_idx(word_idx), .rate_sel(rate_sel), .tick(tick)
    );

    lqm_threshold #(.THR_W(THR_W)) u_thr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .thr_tc(thr_tc)
    );

    lqm_overhead #(
        .ERR_W(ERR_W), .WORD_W(WORD_W), .OVH_WORD(OVH_WORD), .OVH_W(OVH_W)
    ) u_ovh (
        .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .word_idx(word_idx),
        .err_a(err_a), .err_b(err_b), .err_c(err_c),
        .sel_a(sel_a), .sel_b(sel_b), .ovh_cnt(ovh_cnt), .ovh_tc(ovh_tc)
    );

    assign credit = thr_tc && ovh_tc;

    lqm_quality #(.Q_W(Q_W), .LOW_MARK(LOW_MARK)) u_q (
        .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .credit(credit),
        .quality(quality), .link_err(link_err)
    );
endmodule

// File: rtl/lqm_checker.sv
module lqm_checker #(
    parameter int WORD_W   = 5,
    parameter int Q_W      = 4,
    parameter int OVH_W    = 4,
    parameter int OVH_WORD = 28,
    parameter int LOW_MARK = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_stb,
    input logic [WORD_W-1:0] word_idx,
    input logic              thr_tc,
    input logic              ovh_tc,
    input logic [OVH_W-1:0]  ovh_cnt,
    input logic [Q_W-1:0]    quality,
    input logic              link_err
);
    logic ovh_load;
    assign ovh_load = scan_stb && (word_idx == WORD_W'(OVH_WORD));

    // R8: quality is frozen between strobes
    a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_stb |=> $stable(quality));

    // R6: both credits raise quality by exactly one
    a_r6_rise_on_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_stb && thr_tc && ovh_tc && !(&quality)) |=> (quality == $past(quality) + 1'b1));

    // R6: no wrap above the top value
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (&quality) |=> (quality != '0));

    // R7: a missing credit lowers quality by exactly one
    a_r7_fall_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_stb && !(thr_tc && ovh_tc) && (quality != '0)) |=> (quality == $past(quality) - 1'b1));

    // R7: no wrap below zero
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (quality == '0) |=> !(&quality));

    // R4: the overhead preset always carries a set top bit
    a_r4_preset_msb: assert property (@(posedge clk) disable iff (!rst_n)
        ovh_load |=> ovh_cnt[OVH_W-1]);

    // R5: terminal count is held until the next overhead load
    a_r5_tc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ovh_tc && !ovh_load) |=> ovh_tc);

    // R9: flag rises only when quality steps down onto the low mark
    a_r9_flag_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_err) |-> (quality == Q_W'(LOW_MARK)));
endmodule

bind link_quality_monitor lqm_checker #(
    .WORD_W(WORD_W), .Q_W(Q_W), .OVH_W(ERR_W + 1),
    .OVH_WORD(OVH_WORD), .LOW_MARK(LOW_MARK)
) u_lqm_checker (
    .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .word_idx(word_idx),
    .thr_tc(thr_tc), .ovh_tc(ovh_tc), .ovh_cnt(ovh_cnt),
    .quality(quality), .link_err(link_err)
);

// File: tb/link_quality_monitor_bench.sv
module link_quality_monitor_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_stb = 1'b0;
    logic [4:0] word_idx = '0;
    logic [1:0] rate_sel = '0;
    logic [2:0] err_a = '0, err_b = '0, err_c = '0;
    logic       sel_a = 1'b0, sel_b = 1'b0;
    logic [3:0] quality;
    logic       link_err;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    int m_pre = 0;
    int m_thr = 0;
    int m_ovh = 15;
    int m_q   = 15;

    always #(PERIOD/2) clk = ~clk;

    link_quality_monitor u_link_quality_monitor (
        .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .word_idx(word_idx),
        .rate_sel(rate_sel), .err_a(err_a), .err_b(err_b), .err_c(err_c),
        .sel_a(sel_a), .sel_b(sel_b), .quality(quality), .link_err(link_err)
    );

    task automatic compare(input string tag);
        total++;
        if (quality !== 4'(m_q)) begin
            bad++;
            $display("FAIL %s quality actual=%0d expected=%0d", tag, quality, m_q);
        end
        total++;
        if (link_err !== (m_q <= 3)) begin
            bad++;
            $display("FAIL %s link_err actual=%0b expected=%0b", tag, link_err, (m_q <= 3));
        end
    endtask

    // model of one clock with the inputs currently driven
    task automatic model_step();
        bit credit;
        bit tap;
        int e;
        if (!scan_stb) return;
        credit = (m_thr == 15) && (m_ovh == 15);
        if (credit) begin
            if (m_q < 15) m_q++;
        end else if (m_q > 0) begin
            m_q--;
        end
        if (word_idx >= 1 && word_idx <= 23) begin
            case (rate_sel)
                2'd0: tap = 1'b1;
                2'd1: tap = (m_pre % 10) == 9;
                2'd2: tap = (m_pre % 100) == 99;
                default: tap = (m_pre % 1000) == 999;
            endcase
            if (tap) m_thr = (m_thr + 1) % 16;
            m_pre = (m_pre + 1) % 1000;
        end
        if (word_idx == 5'd28) begin
            e = sel_a ? int'(err_a) : (sel_b ? int'(err_b) : int'(err_c));
            m_ovh = 15 - e;
        end else if (m_ovh != 15) begin
            m_ovh++;
        end
    endtask

    task automatic step(input bit stb, input int w, input string tag);
        scan_stb = stb;
        word_idx = 5'(w);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic frames(input int n, input bit gaps, input string tag);
        for (int f = 0; f < n; f++) begin
            for (int w = 0; w < 32; w++) begin
                step(1'b1, w, tag);
                if (gaps && (w % 7 == 3)) step(1'b0, w, tag);
            end
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R10 reset state");

        for (int i = 0; i < 5; i++) step(1'b0, 5, "R8 idle");

        // credit path from reset: overhead at 15, threshold climbs
        rate_sel = 2'd0;
        frames(2, 1'b1, "R3 R7 rate0 drain");
        frames(1, 1'b0, "R9 low flag");

        // strobes only in words outside the data range
        for (int i = 0; i < 40; i++) step(1'b1, 24 + (i % 4), "R1 outside words");
        for (int i = 0; i < 40; i++) step(1'b1, (i % 2) ? 0 : 31, "R1 outside words");

        // bring threshold to 15, then slow rate so it dwells there
        while (m_thr != 15) step(1'b1, 5, "R3 align");
        rate_sel = 2'd3;
        err_a = 3'd0; err_b = 3'd0; err_c = 3'd0;
        frames(2, 1'b0, "R6 climb saturate");

        // overhead error loads from each source
        err_a = 3'd4; err_b = 3'd1; err_c = 3'd7;
        sel_a = 1'b1; sel_b = 1'b1;
        frames(2, 1'b1, "R4 first source");
        sel_a = 1'b0;
        frames(2, 1'b0, "R4 second source");
        sel_b = 1'b0;
        frames(2, 1'b0, "R4 R5 fallback source");
        err_c = 3'd2;
        frames(3, 1'b1, "R5 recovery");

        // decade taps
        rate_sel = 2'd1;
        err_c = 3'd0;
        frames(12, 1'b0, "R2 rate 1 in 10");
        rate_sel = 2'd2;
        frames(50, 1'b0, "R2 rate 1 in 100");
        rate_sel = 2'd3;
        frames(50, 1'b0, "R2 rate 1 in 1000");
        err_c = 3'd5;
        frames(4, 1'b1, "R7 R9 errors");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule